// File: doc/BRIEF.md
# Page Write Latch with Timed Commit

This block sits behind a serial memory slave's byte decoder. During a write transaction it gathers incoming data bytes into a one-row buffer of up to `PAGE_BYTES` entries, each at the in-row offset given by an address counter. The counter is loaded with the start address from the transaction header. A per-entry valid mask records which offsets were written.

When the decoder reports a bus STOP that lands in the slot right after a data-byte acknowledge, and at least one byte has been latched, the block enters a self-timed write cycle. It raises `busy` for exactly `WRITE_CLKS` system clocks. In the first clocks of that window it walks the row offsets in ascending order and issues one array write per clock, only for the offsets marked valid. When the cycle ends, the counter is left pointing one past the last byte written. A STOP in any other slot throws the latched bytes away. A write-inhibit input keeps bytes out of the buffer entirely.

Top module: `page_write_latch`

## Requirements
- R1: After synchronous reset, `busy` and `mem_we` are 0 and `addr_cnt` is 0.
- R2: While idle, a `byte_stb` with `wr_inhibit` low stores `byte_in` at offset `addr_cnt[5:0]`. It then advances only those 6 low bits, so offset 63 wraps to 0 while bits 15..6 stay unchanged. The new count is visible the cycle after the strobe.
- R3: A byte stored at an offset that already holds a latched byte replaces it. Only the newest value is written to the array.
- R4: A `stop_seen` pulse with `stop_after_ack` = 1 while idle and with at least one byte latched starts the write cycle. `busy` is 1 in the cycle after the pulse.
- R5: A `stop_seen` pulse with `stop_after_ack` = 0 discards every latched byte. No write cycle starts, and those bytes are never written to the array later.
- R6: A `byte_stb` while `wr_inhibit` is 1 latches nothing and leaves `addr_cnt` unchanged. A following STOP then causes no write cycle and no array write.
- R7: Once raised, `busy` stays 1 for exactly `WRITE_CLKS` consecutive cycles.
- R8: `mem_we` is 1 only while `busy` is 1, at most once per cycle. It is asserted once for each latched offset, in ascending offset order. `mem_addr` is {row bits 15..6 of `addr_cnt`, offset} and `mem_wdata` is the latched byte. All writes finish within the first `PAGE_BYTES` busy cycles.
- R9: In the cycle after `busy` falls, `addr_cnt` equals the full 16-bit address of the last stored byte plus one. This increment carries into the row bits.
- R10: While `busy` is 1, `addr_load`, `byte_stb` and `stop_seen` have no effect.
- R11: While idle, `addr_load` sets `addr_cnt` to `addr_in` and discards any latched bytes. It takes priority over a `byte_stb` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load start address (one-cycle pulse) |
| addr_in | input | ADDR_W | Start address to load |
| byte_stb | input | 1 | Accepted data byte strobe (one-cycle pulse) |
| byte_in | input | DATA_W | Data byte |
| wr_inhibit | input | 1 | Write protect; blocks latching |
| stop_seen | input | 1 | STOP condition observed (one-cycle pulse) |
| stop_after_ack | input | 1 | STOP fell in the slot just after a data-byte ACK |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| addr_cnt | output | ADDR_W | Current address counter |

## Verification
Every control input is registered once, so a strobe or load shows up in `addr_cnt` in the cycle after it. A qualifying STOP raises `busy` in the next cycle, and the first array write can appear in that same cycle. Array writes then follow at a rate of one per cycle, stepping through offsets over at most `PAGE_BYTES` cycles. `busy` is counted for exactly `WRITE_CLKS` cycles, and the final counter value is read in the first idle cycle after it. Inputs are driven and outputs sampled on the falling clock edge, so each value is read one half-period after the edge that produced it. A monitor pops the expected address/data pair the bench queued when it modelled the commit, and flags any write it did not expect.

// File: rtl/pwl_pkg.sv
// Shared types for the page write latch.
// Assumes: nothing beyond IEEE 1800-2017.
package pwl_pkg;

    // Phase of the commit sequencer.
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_COMMIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pwl_row_buffer.sv
// Row buffer: PAGE_BYTES data entries plus a valid mask.
// Writes land at wr_off; clr drops every valid bit and wins over a write.
// Assumes: wr_off and rd_off are in-row offsets below PAGE_BYTES.
module pwl_row_buffer #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    // Store entries and maintain the valid mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                slot_data[i] <= '0;
            end
        end else if (clr) begin
            slot_vld <= '0;
        end else if (wr_en) begin
            slot_data[wr_off] <= wr_data;
            slot_vld[wr_off]  <= 1'b1;
        end
    end

    // Read port for the commit scan.
    always_comb begin
        rd_data   = slot_data[rd_off];
        rd_valid  = slot_vld[rd_off];
        any_valid = |slot_vld;
    end

endmodule

// File: rtl/pwl_addr_counter.sv
// Address counter: loads a start address and steps only the in-row offset
// on each stored byte. It remembers the last stored offset so that, when
// the write cycle finishes, it can point one past the last byte with a full
// carry into the row bits.
// Assumes: at most one of load/step/finish is active per cycle.
module pwl_addr_counter #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] cnt,
    output logic [OFF_W-1:0]  cur_off
);

    logic [OFF_W-1:0] last_off;

    // Counter update: load, in-row step, or end-of-cycle advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            last_off <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt[OFF_W-1:0] <= cnt[OFF_W-1:0] + OFF_W'(1);
            last_off       <= cnt[OFF_W-1:0];
        end else if (finish) begin
            cnt <= {cnt[ADDR_W-1:OFF_W], last_off} + ADDR_W'(1);
        end
    end

    // Expose the current in-row offset.
    always_comb cur_off = cnt[OFF_W-1:0];

endmodule

// File: rtl/pwl_commit_seq.sv
// Commit sequencer: on start, holds busy for WRITE_CLKS cycles and runs a
// scan index from 0 up to PAGE_BYTES, one step per cycle.
// Assumes: WRITE_CLKS >= PAGE_BYTES so the scan ends inside the window.
module pwl_commit_seq
    import pwl_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int WRITE_CLKS = 250000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int TMR_W     = $clog2(WRITE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             scan_live,
    output logic [OFF_W-1:0] scan_off
);

    seq_state_e        state;
    logic [TMR_W-1:0]  tmr;
    logic [OFF_W:0]    scan_idx;

    // Sequence state, write timer and scan index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            tmr      <= '0;
            scan_idx <= '0;
        end else if (state == SEQ_IDLE) begin
            if (start) begin
                state    <= SEQ_COMMIT;
                tmr      <= '0;
                scan_idx <= '0;
            end
        end else begin
            tmr <= tmr + TMR_W'(1);
            if (done) begin
                state <= SEQ_IDLE;
            end
            if (scan_live) begin
                scan_idx <= scan_idx + (OFF_W+1)'(1);
            end
        end
    end

    // Status decode.
    always_comb begin
        busy      = (state == SEQ_COMMIT);
        done      = busy && (tmr == TMR_W'(WRITE_CLKS - 1));
        scan_live = busy && (scan_idx < (OFF_W+1)'(PAGE_BYTES));
        scan_off  = scan_idx[OFF_W-1:0];
    end

endmodule

// File: rtl/page_write_latch.sv
// Page write latch: gathers a row of write data, then commits the valid
// entries to the array during a self-timed cycle of WRITE_CLKS clocks.
// Assumes: inputs are single-cycle pulses from a byte-level protocol decoder,
// WRITE_CLKS >= PAGE_BYTES, and PAGE_BYTES is a power of two.
module page_write_latch #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int WRITE_CLKS = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              wr_inhibit,
    input  logic              stop_seen,
    input  logic              stop_after_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] addr_cnt
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic             load_ok, stb_ok, stop_ok, start, clr, done;
    logic             scan_live, rd_valid, any_valid;
    logic [OFF_W-1:0] scan_off, cur_off;
    logic [DATA_W-1:0] rd_data;

    // Qualify requests: everything is ignored during the write cycle.
    always_comb begin
        load_ok = !busy && addr_load;
        stb_ok  = !busy && !addr_load && byte_stb && !wr_inhibit;
        stop_ok = !busy && stop_seen;
        start   = stop_ok && stop_after_ack && any_valid;
        clr     = load_ok || (stop_ok && !start) || done;
    end

    pwl_addr_counter #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (addr_in),
        .step     (stb_ok),
        .finish   (done),
        .cnt      (addr_cnt),
        .cur_off  (cur_off)
    );

    pwl_row_buffer #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (stb_ok),
        .wr_off    (cur_off),
        .wr_data   (byte_in),
        .rd_off    (scan_off),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pwl_commit_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .WRITE_CLKS (WRITE_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .scan_live (scan_live),
        .scan_off  (scan_off)
    );

    // Array write port driven by the scan.
    always_comb begin
        mem_we    = scan_live && rd_valid;
        mem_addr  = {addr_cnt[ADDR_W-1:OFF_W], scan_off};
        mem_wdata = rd_data;
    end

endmodule

// File: rtl/pwl_checker.sv
// Protocol checker for page_write_latch, attached with bind below.
// Assumes: the same parameters as the bound instance.
module pwl_checker #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 64,
    parameter int WRITE_CLKS = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_seen,
    input logic              stop_after_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic [ADDR_W-1:0] addr_cnt
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    int unsigned busy_run;

    // Count consecutive busy cycles to check the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= busy ? busy_run + 1 : 0;
    end

    assert_we_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0])));

    assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen && stop_after_ack));

    assert_window_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == WRITE_CLKS));

    assert_cnt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_cnt));

endmodule

bind page_write_latch pwl_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WRITE_CLKS (WRITE_CLKS)
) u_pwl_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_seen      (stop_seen),
    .stop_after_ack (stop_after_ack),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .busy           (busy),
    .addr_cnt       (addr_cnt)
);

// File: tb/page_write_latch_test.sv
// Scoreboard bench: drivers model the latch and queue expected array writes;
// a monitor pops and compares them as the design issues writes.
module page_write_latch_test;

    localparam int AW   = 16;
    localparam int PB   = 64;
    localparam int WCLK = 80;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          addr_load, byte_stb, wr_inhibit, stop_seen, stop_after_ack;
    logic [AW-1:0] addr_in;
    logic [7:0]    byte_in;
    logic          mem_we, busy;
    logic [AW-1:0] mem_addr, addr_cnt;
    logic [7:0]    mem_wdata;

    always #10 clk = ~clk;

    page_write_latch #(
        .ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PB), .WRITE_CLKS(WCLK)
    ) uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .wr_inhibit(wr_inhibit),
        .stop_seen(stop_seen), .stop_after_ack(stop_after_ack),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .addr_cnt(addr_cnt)
    );

    int          checks = 0;
    int          errors = 0;
    logic [23:0] exp_q[$];
    string       wr_tag = "R8";

    // Reference model state.
    logic [AW-1:0] m_cnt = '0;
    logic [5:0]    m_last = '0;
    logic [7:0]    m_data [PB];
    logic          m_vld  [PB];

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < PB; i++) m_vld[i] = 1'b0;
    endtask

    // Monitor: compare each array write with the head of the queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && mem_we === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s actual=%0h expected=none (unexpected write)",
                         wr_tag, {mem_addr, mem_wdata});
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", wr_tag,
                             {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic do_load(logic [AW-1:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
        m_cnt = a;
        m_clear();
        chk("R11", addr_cnt, a);
    endtask

    task automatic do_byte(logic [7:0] d);
        byte_stb = 1'b1; byte_in = d;
        @(negedge clk);
        byte_stb = 1'b0;
        if (!wr_inhibit) begin
            m_data[m_cnt[5:0]] = d;
            m_vld[m_cnt[5:0]]  = 1'b1;
            m_last             = m_cnt[5:0];
            m_cnt[5:0]         = m_cnt[5:0] + 6'd1;
        end
        chk(wr_inhibit ? "R6" : "R2", addr_cnt, m_cnt);
    endtask

    // STOP pulse; models commit or discard and follows the write cycle.
    task automatic do_stop(logic after_ack, bit inject, string tag);
        bit any = 1'b0;
        int n;
        for (int i = 0; i < PB; i++) any |= m_vld[i];
        if (after_ack && any) begin
            for (int i = 0; i < PB; i++)
                if (m_vld[i]) exp_q.push_back({m_cnt[15:6], 6'(i), m_data[i]});
        end
        stop_seen = 1'b1; stop_after_ack = after_ack;
        @(negedge clk);
        stop_seen = 1'b0; stop_after_ack = 1'b0;
        if (!(after_ack && any)) begin
            m_clear();
            for (int k = 0; k < 3; k++) begin
                chk(tag, busy, 1'b0);
                @(negedge clk);
            end
            return;
        end
        chk("R4", busy, 1'b1);
        n = 1;
        if (inject) begin
            // R10: requests during busy must have no effect.
            addr_load = 1'b1; addr_in = 16'h3000; byte_in = 8'h77;
            byte_stb = 1'b1; stop_seen = 1'b1; stop_after_ack = 1'b1;
            @(negedge clk);
            addr_load = 1'b0; byte_stb = 1'b0; stop_seen = 1'b0; stop_after_ack = 1'b0;
            if (busy) n++;
        end
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk("R7", n, WCLK);
        chk("R8", exp_q.size(), 0);
        m_cnt = {m_cnt[15:6], m_last} + 16'd1;
        m_clear();
        chk(inject ? "R10" : "R9", addr_cnt, m_cnt);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_clear();
        rst_n = 1'b0; addr_load = 0; addr_in = '0; byte_stb = 0; byte_in = '0;
        wr_inhibit = 0; stop_seen = 0; stop_after_ack = 0;
        repeat (3) @(negedge clk);
        chk("R1", busy, 1'b0);
        chk("R1", mem_we, 1'b0);
        chk("R1", addr_cnt, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Single byte commit (R4, R8, R9).
        do_load(16'h1234); do_byte(8'hA5); do_stop(1'b1, 0, "R4");
        chk("R9", addr_cnt, 16'h1235);

        // Short page.
        do_load(16'h0043);
        for (int i = 0; i < 5; i++) do_byte(8'h10 + 8'(i));
        do_stop(1'b1, 0, "R4");
        chk("R9", addr_cnt, 16'h0048);

        // In-row wrap R2: offsets 62,63,0,1 of row 0x0080.
        wr_tag = "R2";
        do_load(16'h00BE);
        for (int i = 0; i < 4; i++) do_byte(8'hC0 + 8'(i));
        chk("R2", addr_cnt, 16'h0082);
        do_stop(1'b1, 0, "R2");
        chk("R9", addr_cnt, 16'h0082);

        // Overwrite R3: 65 bytes, offset 0 gets the last one.
        wr_tag = "R3";
        do_load(16'h0100);
        for (int i = 0; i < 65; i++) do_byte(8'(i + 1));
        do_stop(1'b1, 0, "R3");
        chk("R3", addr_cnt, 16'h0101);

        // Carry into row bits R9.
        wr_tag = "R8";
        do_load(16'h013F); do_byte(8'h5A);
        chk("R2", addr_cnt, 16'h0100);
        do_stop(1'b1, 0, "R4");
        chk("R9", addr_cnt, 16'h0140);

        // Discard on misplaced STOP R5.
        wr_tag = "R5";
        do_load(16'h0200); do_byte(8'h01); do_byte(8'h02);
        do_stop(1'b0, 0, "R5");
        do_byte(8'h33);
        do_stop(1'b1, 0, "R5");
        chk("R5", addr_cnt, 16'h0203);

        // Write inhibit R6.
        wr_tag = "R6";
        do_load(16'h0400);
        wr_inhibit = 1'b1;
        for (int i = 0; i < 3; i++) do_byte(8'hE0 + 8'(i));
        chk("R6", addr_cnt, 16'h0400);
        do_stop(1'b1, 0, "R6");
        wr_inhibit = 1'b0;

        // Reload discards R11.
        wr_tag = "R11";
        do_load(16'h0500); do_byte(8'h11);
        do_load(16'h0600); do_byte(8'h22);
        do_stop(1'b1, 0, "R11");
        chk("R11", addr_cnt, 16'h0601);

        // Requests during busy ignored R10.
        wr_tag = "R10";
        do_load(16'h0700); do_byte(8'h99);
        do_stop(1'b1, 1, "R10");
        chk("R10", addr_cnt, 16'h0701);
        do_stop(1'b1, 0, "R10");

        repeat (4) @(negedge clk);
        chk("R8", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule